// File: doc/BRIEF.md
# Buffered Memory Pattern Tester

This block exercises an external memory with data held in its own 256-word pattern buffer. A host loads the buffer, sets a memory word address, then writes a command word. The command starts a burst right away. A write burst copies consecutive buffer words, beginning at a chosen buffer index, to consecutive memory words. A read burst fetches memory words and compares each one with the buffer word it should match.

The compare result is a sticky pass flag. A single mismatch clears it, and it stays clear across any number of later bursts until a command carrying the clear bit sets it again. Software can therefore sweep a large memory region one burst at a time and inspect the flag once at the end. The memory side is a generic request/ready port for addresses and write data. Read data comes back in order, with a valid strobe.

Top module: `pattern_tester`

## Requirements
- R1: After reset the status word reads 0x2 (busy bit 0 is clear, pass bit 1 is set), and no memory request is raised.
- R2: Command word fields: bits [7:0] hold burst length minus one, bits [15:8] hold the starting buffer index, bit 16 selects read-and-compare (1) or write (0), bit 17 sets the pass flag before the burst runs, and bit 18 selects dual order. A length field of 31 or more gives exactly 32 words.
- R3: A write burst of n words issues n requests with the write strobe high. The address of word k is base+k and its data is buffer[(start+k) mod 256], in ascending k. Each word waits for ready and is held stable until ready is seen.
- R4: A read burst issues n requests with the write strobe low. The returned words are compared in order with the expected buffer words, and any difference clears the pass flag.
- R5: The pass flag, once clear, stays clear through later bursts that match. It is set again only by a command with bit 17.
- R6: Status bit 0 (busy) is high from the cycle after the command write. It falls after the last request is accepted (write) or after the last word is returned (read).
- R7: A command written while busy is dropped. It issues no requests and leaves the running burst unchanged.
- R8: The buffer index wraps modulo 256 within a burst.
- R9: In dual order with h = ceil(n/2), request i carries word i/2 when i is even and word h+(i-1)/2 when i is odd. Responses are compared in that same order.
- R10: Host map: offset 0 is command (write) and status (read), offset 1 is the address register (read back as written), and offsets 0x100 to 0x1FF are the buffer. Read data appears one clock after the address.
- R11: The memory address is captured when the command is accepted. Writing the address register during a burst does not affect that burst, but the next command uses the new value.
- R12: A returned-data strobe received outside a read burst has no effect on the pass flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 9 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Returned read word valid |
| mem_rdata | input | 32 | Returned read word |

## Verification
Write bursts and read bursts are tried at full length, at a clamped oversize length, with a start index that wraps, and in dual order. Each case separates a wrong address or word order from a wrong buffer index. Ready is withheld at random, which exposes requests that move or drop while stalled. A planted memory corruption followed by a clean burst shows whether the flag is sticky, and a clear command afterwards shows that it can be set again. Commands and address writes made while busy, plus a stray return strobe while idle, show that those inputs leave both the burst and the flag unchanged.

// File: rtl/pattern_tester_pkg.sv
package pattern_tester_pkg;
   localparam int unsigned CMD_BITS = 19;

   typedef struct packed {
      logic       dual;
      logic       clr;
      logic       rd;
      logic [7:0] start;
      logic [7:0] lenm1;
   } cmd_t;

   function automatic cmd_t cmd_decode(input logic [CMD_BITS-1:0] w);
      cmd_t c;
      c.lenm1 = w[7:0];
      c.start = w[15:8];
      c.rd    = w[16];
      c.clr   = w[17];
      c.dual  = w[18];
      return c;
   endfunction
endpackage

// File: rtl/pattern_tester_buffer.sv
module pattern_tester_buffer #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] host_idx,
   output logic [DW-1:0] host_q,
   input  logic [IW-1:0] a_idx,
   output logic [DW-1:0] a_data,
   input  logic [IW-1:0] b_idx,
   output logic [DW-1:0] b_data
);
   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
      host_q <= store[host_idx];
   end

   assign a_data = store[a_idx];
   assign b_data = store[b_idx];
endmodule

// File: rtl/pattern_tester_seq.sv
module pattern_tester_seq #(
   parameter int unsigned AW        = 32,
   parameter int unsigned IW        = 8,
   parameter int unsigned MAX_BURST = 32,
   parameter bit          DUAL_EN   = 1'b1,
   localparam int unsigned CW       = $clog2(MAX_BURST + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [CW-1:0] burst_n,
   input  logic [IW-1:0] start_idx,
   input  logic          rd,
   input  logic          dual,
   input  logic [AW-1:0] base_addr,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [IW-1:0] issue_idx,
   output logic          cmp_fire,
   output logic [IW-1:0] cmp_idx,
   output logic [CW-1:0] n_q,
   output logic [CW-1:0] issue_cnt
);
   logic [CW-1:0] resp_cnt;
   logic [IW-1:0] start_q;
   logic [AW-1:0] base_q;
   logic          rd_q;
   logic          dual_q;
   logic [CW-1:0] issue_k;
   logic [CW-1:0] resp_k;
   logic          issue_fire;

   assign mem_req    = busy && (issue_cnt < n_q);
   assign mem_we     = ~rd_q;
   assign issue_fire = mem_req && mem_ready;
   assign cmp_fire   = busy && rd_q && mem_rvalid && (resp_cnt < n_q);

   function automatic logic [CW-1:0] slot_word(input logic [CW-1:0] i,
                                                input logic [CW-1:0] n,
                                                input logic          dl);
      logic [CW-1:0] half;
      half = CW'((n + CW'(1)) >> 1);
      if (!dl)       return i;
      else if (i[0]) return half + (i >> 1);
      else           return i >> 1;
   endfunction

   generate
      if (DUAL_EN) begin : g_dual
         assign issue_k = slot_word(issue_cnt, n_q, dual_q);
         assign resp_k  = slot_word(resp_cnt, n_q, dual_q);
      end else begin : g_plain
         assign issue_k = issue_cnt;
         assign resp_k  = resp_cnt;
      end
   endgenerate

   assign mem_addr  = base_q + AW'(issue_k);
   assign issue_idx = start_q + IW'(issue_k);
   assign cmp_idx   = start_q + IW'(resp_k);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         issue_cnt <= '0;
         resp_cnt  <= '0;
         n_q       <= CW'(1);
         start_q   <= '0;
         base_q    <= '0;
         rd_q      <= 1'b0;
         dual_q    <= 1'b0;
      end else if (go && !busy) begin
         busy      <= 1'b1;
         issue_cnt <= '0;
         resp_cnt  <= '0;
         n_q       <= burst_n;
         start_q   <= start_idx;
         base_q    <= base_addr;
         rd_q      <= rd;
         dual_q    <= dual;
      end else if (busy) begin
         if (issue_fire) issue_cnt <= issue_cnt + CW'(1);
         if (cmp_fire)   resp_cnt  <= resp_cnt + CW'(1);
         if (!rd_q && issue_fire && (issue_cnt + CW'(1) == n_q)) busy <= 1'b0;
         if (rd_q && cmp_fire && (resp_cnt + CW'(1) == n_q))     busy <= 1'b0;
      end
   end
endmodule

// File: rtl/pattern_tester_cmp.sv
module pattern_tester_cmp #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          fire,
   input  logic [DW-1:0] expected,
   input  logic [DW-1:0] got,
   output logic          pass
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pass <= 1'b1;
      else if (clear)                     pass <= 1'b1;
      else if (fire && (got != expected)) pass <= 1'b0;
   end
endmodule

// File: rtl/pattern_tester.sv
module pattern_tester
   import pattern_tester_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned BUF_DEPTH = 256,
   parameter int unsigned MAX_BURST = 32,
   parameter bit          DUAL_EN   = 1'b1,
   localparam int unsigned IW       = $clog2(BUF_DEPTH),
   localparam int unsigned HAW      = IW + 1,
   localparam int unsigned CW       = $clog2(MAX_BURST + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           host_wr,
   input  logic [HAW-1:0] host_addr,
   input  logic [DW-1:0]  host_wdata,
   output logic [DW-1:0]  host_rdata,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic           mem_ready,
   input  logic           mem_rvalid,
   input  logic [DW-1:0]  mem_rdata
);
   generate
      if (DW < CMD_BITS) begin : g_err_dw
         $error("data width too narrow for the command word");
      end
      if ((1 << IW) != BUF_DEPTH || IW > 8) begin : g_err_depth
         $error("buffer depth must be a power of two up to 256");
      end
      if (MAX_BURST < 1 || MAX_BURST > BUF_DEPTH) begin : g_err_burst
         $error("burst limit must lie between 1 and the buffer depth");
      end
   endgenerate

   logic          sel_buf;
   logic [IW-1:0] host_idx;
   logic          reg_cmd_wr;
   logic          reg_adr_wr;
   logic          busy;
   logic          go;
   logic          go_clr;
   logic          pass;
   cmd_t          cmd;
   logic [CW-1:0] burst_n;
   logic [AW-1:0] addr_q;
   logic          rd_sel_buf_q;
   logic [DW-1:0] reg_rd_q;
   logic [DW-1:0] buf_host_q;
   logic [IW-1:0] issue_idx;
   logic [IW-1:0] cmp_idx;
   logic [DW-1:0] cmp_exp;
   logic          cmp_fire;
   logic [CW-1:0] n_q;
   logic [CW-1:0] issue_cnt;

   assign sel_buf    = host_addr[HAW-1];
   assign host_idx   = host_addr[IW-1:0];
   assign reg_cmd_wr = host_wr && !sel_buf && (host_idx == IW'(0));
   assign reg_adr_wr = host_wr && !sel_buf && (host_idx == IW'(1));
   assign cmd        = cmd_decode(host_wdata[CMD_BITS-1:0]);
   assign go         = reg_cmd_wr && !busy;
   assign go_clr     = go && cmd.clr;
   assign burst_n    = (cmd.lenm1 >= 8'(MAX_BURST - 1)) ? CW'(MAX_BURST)
                                                          : CW'(cmd.lenm1) + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q       <= '0;
         rd_sel_buf_q <= 1'b0;
         reg_rd_q     <= '0;
      end else begin
         if (reg_adr_wr) addr_q <= AW'(host_wdata);
         rd_sel_buf_q <= sel_buf;
         if (host_idx == IW'(0))      reg_rd_q <= DW'({pass, busy});
         else if (host_idx == IW'(1)) reg_rd_q <= DW'(addr_q);
         else                         reg_rd_q <= '0;
      end
   end

   assign host_rdata = rd_sel_buf_q ? buf_host_q : reg_rd_q;

   pattern_tester_buffer #(.DEPTH(BUF_DEPTH), .DW(DW)) u_buffer (
      .clk      (clk),
      .wr_en    (host_wr && sel_buf),
      .wr_idx   (host_idx),
      .wr_data  (host_wdata),
      .host_idx (host_idx),
      .host_q   (buf_host_q),
      .a_idx    (issue_idx),
      .a_data   (mem_wdata),
      .b_idx    (cmp_idx),
      .b_data   (cmp_exp)
   );

   pattern_tester_seq #(.AW(AW), .IW(IW), .MAX_BURST(MAX_BURST), .DUAL_EN(DUAL_EN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .burst_n    (burst_n),
      .start_idx  (IW'(cmd.start)),
      .rd         (cmd.rd),
      .dual       (cmd.dual),
      .base_addr  (addr_q),
      .mem_ready  (mem_ready),
      .mem_rvalid (mem_rvalid),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .issue_idx  (issue_idx),
      .cmp_fire   (cmp_fire),
      .cmp_idx    (cmp_idx),
      .n_q        (n_q),
      .issue_cnt  (issue_cnt)
   );

   pattern_tester_cmp #(.DW(DW)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (go_clr),
      .fire     (cmp_fire),
      .expected (cmp_exp),
      .got      (mem_rdata),
      .pass     (pass)
   );
endmodule

// File: rtl/pattern_tester_checker.sv
module pattern_tester_checker #(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned CW        = 6,
   parameter int unsigned MAX_BURST = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          go_clr,
   input logic          cmd_wr,
   input logic          pass,
   input logic          mem_req,
   input logic          mem_ready,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [CW-1:0] n_q,
   input logic [CW-1:0] issue_cnt
);
   assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_wdata) && $stable(mem_we)));

   assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (n_q != '0 && n_q <= CW'(MAX_BURST) && issue_cnt <= n_q));

   assert_pass_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> $past(go_clr));

   assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> $stable(n_q));
endmodule

bind pattern_tester pattern_tester_checker #(
   .AW(AW), .DW(DW), .CW(CW), .MAX_BURST(MAX_BURST)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .go_clr    (go_clr),
   .cmd_wr    (reg_cmd_wr),
   .pass      (pass),
   .mem_req   (mem_req),
   .mem_ready (mem_ready),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .n_q       (n_q),
   .issue_cnt (issue_cnt)
);

// File: tb/pattern_tester_bench.sv
module pattern_tester_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [8:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit inject = 0;
   bit pass_m = 1;

   logic [31:0] mem_m [0:1023];
   logic [31:0] buf_m [0:255];
   logic [31:0] eq_addr[$];
   logic [31:0] eq_data[$];
   bit          eq_we[$];
   logic [31:0] rq_data[$];
   int          rq_time[$];

   always #5 clk = ~clk;

   pattern_tester u_pattern_tester (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Memory model and per-clock comparison of requests against the reference queue
   always @(negedge clk) begin
      cyc++;
      mem_ready = ($urandom % 4) != 0;
      if (inject) begin
         mem_rvalid = 1'b1; mem_rdata = 32'hDEAD0BAD; inject = 0;
      end else if (rq_data.size() != 0 && rq_time[0] <= cyc) begin
         mem_rvalid = 1'b1; mem_rdata = rq_data.pop_front(); void'(rq_time.pop_front());
      end else begin
         mem_rvalid = 1'b0;
      end
      #1;
      if (rst_n && mem_req && mem_ready) begin
         if (eq_addr.size() == 0) begin
            check("R7 unexpected request", mem_addr, 32'hFFFFFFFF);
         end else begin
            check("R3/R4 request address", mem_addr, eq_addr.pop_front());
            check("R3/R4 request direction", {31'b0, mem_we}, {31'b0, eq_we.pop_front()});
            if (mem_we) begin
               check("R3 write data", mem_wdata, eq_data.pop_front());
               mem_m[mem_addr[9:0]] = mem_wdata;
            end else begin
               void'(eq_data.pop_front());
               rq_data.push_back(mem_m[mem_addr[9:0]]);
               rq_time.push_back(cyc + 2);
            end
         end
      end
   end

   task automatic host_write(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      s = 32'h1;
      while (s[0]) host_read(9'h000, s);
   endtask

   // Reference: expected requests and pass flag from the requirement text
   task automatic expect_burst(input int lenm1, input int start, input bit rd,
                               input bit clr, input bit dual, input int base);
      int n, h, k;
      n = (lenm1 >= 31) ? 32 : lenm1 + 1;
      h = (n + 1) / 2;
      if (clr) pass_m = 1;
      for (int i = 0; i < n; i++) begin
         k = !dual ? i : ((i % 2) ? h + i / 2 : i / 2);
         eq_addr.push_back(32'(base + k));
         eq_we.push_back(!rd);
         eq_data.push_back(buf_m[(start + k) % 256]);
      end
      if (rd)
         for (int j = 0; j < n; j++)
            if (mem_m[(base + j) % 1024] !== buf_m[(start + j) % 256]) pass_m = 0;
   endtask

   task automatic run_burst(input int lenm1, input int start, input bit rd,
                            input bit clr, input bit dual, input int base, input bit set_addr);
      if (set_addr) host_write(9'h001, 32'(base));
      expect_burst(lenm1, start, rd, clr, dual, base);
      host_write(9'h000, {13'b0, dual, clr, rd, 8'(start), 8'(lenm1)});
      wait_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 1024; i++) mem_m[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 mem_req idle", {31'b0, mem_req}, 32'h0);
      host_read(9'h000, r);
      check("R1 status after reset", r, 32'h2);

      // R10: load buffer and read back
      for (int i = 0; i < 256; i++) begin
         buf_m[i] = 32'h9E3779B9 * (i + 1) + 32'h1357;
         host_write(9'(9'h100 + i), buf_m[i]);
      end
      host_read(9'h100, r);  check("R10 buffer word 0", r, buf_m[0]);
      host_read(9'h105, r);  check("R10 buffer word 5", r, buf_m[5]);
      host_read(9'h1FF, r);  check("R10 buffer word 255", r, buf_m[255]);
      host_write(9'h001, 32'h40);
      host_read(9'h001, r);  check("R10 address readback", r, 32'h40);

      // R3 then R4: full write burst and matching read
      run_burst(31, 0, 0, 0, 0, 0, 1);
      run_burst(31, 0, 1, 1, 0, 0, 1);
      host_read(9'h000, r);  check("R4 pass after clean read", r, {30'b0, pass_m, 1'b0});

      // R8: index wraps
      run_burst(15, 8'hF8, 0, 0, 0, 32'h100, 1);
      run_burst(15, 8'hF8, 1, 1, 0, 32'h100, 1);
      host_read(9'h000, r);  check("R8 pass after wrapped read", r, {30'b0, pass_m, 1'b0});

      // R2: oversize length clamps to 32
      run_burst(200, 8'h40, 0, 0, 0, 32'h200, 1);
      check("R2 clamp leaves no pending words", 32'(eq_addr.size()), 32'h0);
      run_burst(255, 8'h40, 1, 1, 0, 32'h200, 1);
      host_read(9'h000, r);  check("R2 pass after clamped read", r, {30'b0, pass_m, 1'b0});

      // R9: dual order, odd and even lengths
      run_burst(4, 8'h10, 0, 0, 1, 32'h300, 1);
      run_burst(4, 8'h10, 1, 1, 1, 32'h300, 1);
      run_burst(5, 8'h30, 0, 0, 1, 32'h310, 1);
      run_burst(5, 8'h30, 1, 0, 1, 32'h310, 1);
      host_read(9'h000, r);  check("R9 pass after dual read", r, {30'b0, pass_m, 1'b0});

      // R4 and R5: mismatch clears the flag, it stays clear, then clear command
      mem_m[5] = mem_m[5] ^ 32'h1;
      run_burst(31, 0, 1, 1, 0, 0, 1);
      host_read(9'h000, r);  check("R4 mismatch clears pass", r, 32'h0);
      run_burst(15, 8'hF8, 1, 0, 0, 32'h100, 1);
      host_read(9'h000, r);  check("R5 pass stays clear", r, {30'b0, pass_m, 1'b0});
      run_burst(15, 8'hF8, 1, 1, 0, 32'h100, 1);
      host_read(9'h000, r);  check("R5 clear bit sets pass", r, 32'h2);

      // R6, R7, R11: busy flag, ignored command, address capture
      host_write(9'h001, 32'h100);
      expect_burst(15, 8'hF8, 1, 0, 0, 32'h100);
      host_write(9'h000, {13'b0, 1'b0, 1'b0, 1'b1, 8'hF8, 8'd15});
      host_read(9'h000, r);  check("R6 busy during burst", {31'b0, r[0]}, 32'h1);
      host_write(9'h000, {13'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'd7});
      host_write(9'h001, 32'h3C0);
      wait_idle();
      host_read(9'h000, r);  check("R6 busy clear after burst", r, {30'b0, pass_m, 1'b0});
      check("R7 no words left pending", 32'(eq_addr.size()), 32'h0);
      host_read(9'h001, r);  check("R11 address register updated", r, 32'h3C0);
      run_burst(0, 8'h22, 0, 0, 0, 32'h3C0, 0);
      check("R11 next burst used new address", mem_m[10'h3C0], buf_m[8'h22]);

      // R12: stray return strobe while idle
      @(negedge clk); inject = 1;
      repeat (3) @(negedge clk);
      host_read(9'h000, r);  check("R12 stray strobe ignored", r, 32'h2);

      check("R4 no outstanding returns", 32'(rq_data.size()), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule